// File: doc/BRIEF.md
# Multi-Context Interrupt Arbiter with Register Port

This block gathers level interrupt requests from a set of numbered sources and routes them to several contexts, each of which is a processor or privilege level that takes interrupts. Each source has a programmable priority. Each context has its own enable bitmap, priority threshold and claim/complete register. A context's interrupt output is high while it has work. Software on that context reads its claim register to take the best waiting source. It writes the same ID back to the claim register when servicing ends.

Register access uses a single-cycle request port. A request is accepted while no response is pending. One cycle later the block returns a one-cycle response with read data or an error flag. A small control FSM governs access. ST_IDLE waits for a request. The transition ACCEPT (request high) moves it to ST_RESP, where the response is presented. The transition RETIRE always returns ST_RESP to ST_IDLE. A claim read has side effects. It clears the claimed source's pending bit and holds the source off until completion, so the interrupt outputs settle anew in the cycle after the claim.

Top module: `irq_hub`

## Requirements
- R1: After reset, rsp_valid, err and all irq_o bits are 0, and every priority, enable bit, threshold and pending bit reads as 0.
- R2: A request is accepted when req is high and rsp_valid is low. rsp_valid is then high for exactly the following cycle. A request made while rsp_valid is high is ignored.
- R3: An access whose addr[1:0] is non-zero returns err=1 and rdata=0, and it writes nothing.
- R4: Source n (1..NUM_SRC) has its priority at PRIO_BASE+4*(n-1). Source 0 has no slot. Writes keep the low PRIO_W bits, and reads return them zero-extended.
- R5: Pending word k is at PEND_BASE+4*k. Bit b of word k is source 32*k+b, and bit 0 of word 0 is always 0. Writes to this region are ignored without error. An offset at or past BM_WORDS*4 is an error.
- R6: Enable word k of context c is at EN_BASE+c*EN_STRIDE+4*k, with the same bit mapping as pending. Bits for source 0 and for sources above NUM_SRC always read 0. A word index at or past BM_WORDS is an error.
- R7: In the block of context c at CTX_BASE+c*CTX_STRIDE, offset 0 is the threshold and offset 4 is the claim/complete register. Any other offset is an error.
- R8: An aligned access that falls in no region returns err=1 and rdata=0.
- R9: A claim read returns the enabled, pending source whose priority is strictly above the context threshold, choosing the highest priority and, on ties, the lowest ID. It returns 0 with no side effect if none qualifies. Priority 0 never qualifies.
- R10: A claim clears the source's pending bit and holds it off. A completion write of that ID (1..NUM_SRC) to any claim register releases the hold.
- R11: irq_o[c] is high exactly while some enabled, pending source has priority above threshold c. It reflects a claim from the cycle after the claim.
- R12: A source input held high sets its pending bit on the next clock unless the source is held. A low input sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Level requests; bit i is source i+1 |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rdata | output | 32 | Read data, 0 for writes and errors |
| err | output | 1 | Access error flag |
| irq_o | output | NUM_CTX | Per-context interrupt request |

## Verification
The bench keeps the defaults: 40 sources, 2 contexts, 3-bit priorities, an enable stride of 0x80 and a context stride of 0x1000. With 40 sources the bitmaps span two words. This brings the second pending and enable words into reach, along with the masking of unused upper bits and the error on a third enable word. Two contexts let a claim on one context hold a source that the other context also enables, and let a completion written through the other context's claim register release it. The 3-bit priority field shows write truncation and equal-priority ties.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } state_e;

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
    import irq_hub_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_SRC    = 40,
    parameter int NUM_CTX    = 2,
    parameter int PRIO_BASE  = 'h0000,
    parameter int PEND_BASE  = 'h1000,
    parameter int EN_BASE    = 'h2000,
    parameter int EN_STRIDE  = 'h80,
    parameter int CTX_BASE   = 'h4000,
    parameter int CTX_STRIDE = 'h1000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rg,
    output logic [$clog2(NUM_SRC+1)-1:0] src,
    output logic [((NUM_CTX > 1) ? $clog2(NUM_CTX) : 1)-1:0] ctx,
    output logic [((((NUM_SRC+32)/32) > 1) ? $clog2((NUM_SRC+32)/32) : 1)-1:0] word
);
    localparam int BM_WORDS = (NUM_SRC + 32) / 32;
    localparam int SRC_IW   = $clog2(NUM_SRC + 1);
    localparam int CTX_IW   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
    localparam int WRD_IW   = (BM_WORDS > 1) ? $clog2(BM_WORDS) : 1;
    localparam int EN_SH    = $clog2(EN_STRIDE);
    localparam int CTX_SH   = $clog2(CTX_STRIDE);
    localparam logic [ADDR_W-1:0] PRIO_LEN = ADDR_W'(NUM_SRC * 4);
    localparam logic [ADDR_W-1:0] PEND_LEN = ADDR_W'(BM_WORDS * 4);
    localparam logic [ADDR_W-1:0] EN_LEN   = ADDR_W'(NUM_CTX * EN_STRIDE);
    localparam logic [ADDR_W-1:0] CTX_LEN  = ADDR_W'(NUM_CTX * CTX_STRIDE);

    logic [ADDR_W-1:0] off_p, off_q, off_e, off_c, en_wd, ctx_off;

    // Offsets wrap below a base, so a single upper-bound compare checks both ends.
    always_comb begin
        off_p   = addr - ADDR_W'(PRIO_BASE);
        off_q   = addr - ADDR_W'(PEND_BASE);
        off_e   = addr - ADDR_W'(EN_BASE);
        off_c   = addr - ADDR_W'(CTX_BASE);
        en_wd   = (off_e & ADDR_W'(EN_STRIDE - 1)) >> 2;
        ctx_off = off_c & ADDR_W'(CTX_STRIDE - 1);
        rg   = RG_NONE;
        src  = '0;
        ctx  = '0;
        word = '0;
        if (addr[1:0] != 2'b00) begin
            rg = RG_NONE;
        end else if (off_p < PRIO_LEN) begin
            rg  = RG_PRIO;
            src = SRC_IW'(off_p >> 2) + SRC_IW'(1);
        end else if (off_q < PEND_LEN) begin
            rg   = RG_PEND;
            word = WRD_IW'(off_q >> 2);
        end else if (off_e < EN_LEN) begin
            ctx  = CTX_IW'(off_e >> EN_SH);
            word = WRD_IW'(en_wd);
            if (en_wd < ADDR_W'(BM_WORDS)) rg = RG_EN;
        end else if (off_c < CTX_LEN) begin
            ctx = CTX_IW'(off_c >> CTX_SH);
            if (ctx_off == ADDR_W'(0))      rg = RG_THR;
            else if (ctx_off == ADDR_W'(4)) rg = RG_CLAIM;
        end
    end

endmodule

// File: rtl/irq_hub_select.sv
module irq_hub_select #(
    parameter int NUM_SRC = 40,
    parameter int PRIO_W  = 3,
    parameter int BM_BITS = 64,
    parameter int SRC_IW  = 6
) (
    input  logic [BM_BITS-1:0]             elig,
    input  logic [(NUM_SRC+1)*PRIO_W-1:0]  prio_flat,
    input  logic [PRIO_W-1:0]              thr,
    output logic [SRC_IW-1:0]              id,
    output logic                           hit
);
    logic [PRIO_W-1:0] best_p;

    // Ascending scan with a strict compare keeps the lowest ID on a tie;
    // seeding with the threshold enforces "strictly above".
    always_comb begin
        best_p = thr;
        id     = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (elig[s] && (prio_flat[s*PRIO_W +: PRIO_W] > best_p)) begin
                best_p = prio_flat[s*PRIO_W +: PRIO_W];
                id     = SRC_IW'(s);
            end
        end
        hit = (id != '0);
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC    = 40,
    parameter int NUM_CTX    = 2,
    parameter int PRIO_W     = 3,
    parameter int ADDR_W     = 16,
    parameter int PRIO_BASE  = 'h0000,
    parameter int PEND_BASE  = 'h1000,
    parameter int EN_BASE    = 'h2000,
    parameter int EN_STRIDE  = 'h80,
    parameter int CTX_BASE   = 'h4000,
    parameter int CTX_STRIDE = 'h1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               req,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic               rsp_valid,
    output logic [31:0]        rdata,
    output logic               err,
    output logic [NUM_CTX-1:0] irq_o
);
    localparam int BM_WORDS = (NUM_SRC + 32) / 32;
    localparam int BM_BITS  = BM_WORDS * 32;
    localparam int SRC_IW   = $clog2(NUM_SRC + 1);
    localparam int CTX_IW   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
    localparam int WRD_IW   = (BM_WORDS > 1) ? $clog2(BM_WORDS) : 1;
    localparam logic [BM_BITS-1:0] SRC_MASK =
        ((BM_BITS'(1) << (NUM_SRC + 1)) - BM_BITS'(1)) & ~BM_BITS'(1);

    state_e state_q, state_d;
    region_e               dec_rg;
    logic [SRC_IW-1:0]     dec_src;
    logic [CTX_IW-1:0]     dec_ctx;
    logic [WRD_IW-1:0]     dec_word;

    logic [(NUM_SRC+1)*PRIO_W-1:0] prio_q;
    logic [BM_BITS-1:0]    pend_q, pend_d, busy_q, busy_d, src_vec;
    logic [BM_BITS-1:0]    en_q  [NUM_CTX];
    logic [PRIO_W-1:0]     thr_q [NUM_CTX];
    logic [SRC_IW-1:0]     best_id [NUM_CTX];
    logic [SRC_IW-1:0]     claim_id, done_id;
    logic                  accept, do_claim, do_done;
    logic [31:0]           rd_d, rdata_q;
    logic                  err_q;

    irq_hub_decode #(
        .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
        .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
        .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
    ) u_dec (
        .addr(addr), .rg(dec_rg), .src(dec_src), .ctx(dec_ctx), .word(dec_word)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irq_hub_select #(
            .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .BM_BITS(BM_BITS), .SRC_IW(SRC_IW)
        ) u_sel (
            .elig(pend_q & en_q[c]), .prio_flat(prio_q), .thr(thr_q[c]),
            .id(best_id[c]), .hit(irq_o[c])
        );
    end

    // Next-state logic: ACCEPT and RETIRE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // Access side effects, level capture and read mux
    always_comb begin
        accept   = (state_q == ST_IDLE) && req;
        claim_id = best_id[dec_ctx];
        done_id  = wdata[SRC_IW-1:0];
        do_claim = accept && !we && (dec_rg == RG_CLAIM) && (claim_id != '0);
        do_done  = accept && we && (dec_rg == RG_CLAIM) &&
                   (wdata >= 32'd1) && (wdata <= 32'(NUM_SRC));
        src_vec  = BM_BITS'({src_in, 1'b0});
        pend_d   = (pend_q | (src_vec & ~busy_q)) & SRC_MASK;
        busy_d   = busy_q;
        if (do_done) busy_d[done_id] = 1'b0;
        if (do_claim) begin
            pend_d[claim_id] = 1'b0;
            busy_d[claim_id] = 1'b1;
        end
        rd_d = '0;
        case (dec_rg)
            RG_PRIO:  rd_d = 32'(prio_q[dec_src*PRIO_W +: PRIO_W]);
            RG_PEND:  rd_d = pend_q[dec_word*32 +: 32];
            RG_EN:    rd_d = en_q[dec_ctx][dec_word*32 +: 32];
            RG_THR:   rd_d = 32'(thr_q[dec_ctx]);
            RG_CLAIM: rd_d = 32'(claim_id);
            default:  rd_d = '0;
        endcase
    end

    // State register and storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prio_q  <= '0;
            pend_q  <= '0;
            busy_q  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            for (int c = 0; c < NUM_CTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            busy_q  <= busy_d;
            if (accept) begin
                err_q   <= (dec_rg == RG_NONE);
                rdata_q <= we ? 32'd0 : rd_d;
                if (we) begin
                    case (dec_rg)
                        RG_PRIO: prio_q[dec_src*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
                        RG_EN:   en_q[dec_ctx][dec_word*32 +: 32] <=
                                     wdata & SRC_MASK[dec_word*32 +: 32];
                        RG_THR:  thr_q[dec_ctx] <= wdata[PRIO_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rdata     = rsp_valid ? rdata_q : 32'd0;
        err       = rsp_valid && err_q;
    end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter int ADDR_W   = 16,
    parameter int NUM_CTX  = 2,
    parameter int CTX_BASE = 'h4000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               we,
    input logic [ADDR_W-1:0]  addr,
    input logic               rsp_valid,
    input logic               err,
    input logic [31:0]        rdata,
    input logic [NUM_CTX-1:0] irq_o
);
    localparam logic [ADDR_W-1:0] CLAIM0 = ADDR_W'(CTX_BASE + 4);

    // R2
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !rsp_valid) |=> rsp_valid);

    // R3
    unaligned_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !rsp_valid && (addr[1:0] != 2'b00)) |=> (err && (rdata == 32'd0)));

    // R9
    empty_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !rsp_valid && !we && (addr == CLAIM0) && !irq_o[0]) |=> (rdata == 32'd0));

    // R8
    err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rsp_valid && (rdata == 32'd0)));

endmodule

bind irq_hub irq_hub_chk #(
    .ADDR_W(ADDR_W), .NUM_CTX(NUM_CTX), .CTX_BASE(CTX_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .rsp_valid(rsp_valid), .err(err), .rdata(rdata), .irq_o(irq_o)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src_in = '0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rsp_valid;
    logic [31:0] rdata;
    logic        err;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_hub u_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rsp_valid(rsp_valid), .rdata(rdata),
        .err(err), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        w;
        logic [15:0] a;
        logic [31:0] d;
        logic        e;
        logic [31:0] r;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0000, 32'd5,        1'b0, 32'd0,        4'd4},  // R4
        '{1'b0, 16'h0000, 32'd0,        1'b0, 32'd5,        4'd4},  // R4
        '{1'b1, 16'h0004, 32'hF,        1'b0, 32'd0,        4'd4},  // R4
        '{1'b0, 16'h0004, 32'd0,        1'b0, 32'd7,        4'd4},  // R4 truncation
        '{1'b0, 16'h009C, 32'd0,        1'b0, 32'd0,        4'd4},  // R4 last source
        '{1'b0, 16'h00A0, 32'd0,        1'b1, 32'd0,        4'd8},  // R8
        '{1'b1, 16'h0002, 32'd9,        1'b1, 32'd0,        4'd3},  // R3
        '{1'b0, 16'h0000, 32'd0,        1'b0, 32'd5,        4'd3},  // R3 unchanged
        '{1'b0, 16'h0001, 32'd0,        1'b1, 32'd0,        4'd3},  // R3
        '{1'b1, 16'h2080, 32'hFFFFFFFF, 1'b0, 32'd0,        4'd6},  // R6
        '{1'b0, 16'h2080, 32'd0,        1'b0, 32'hFFFFFFFE, 4'd6},  // R6
        '{1'b1, 16'h2084, 32'hFFFFFFFF, 1'b0, 32'd0,        4'd6},  // R6
        '{1'b0, 16'h2084, 32'd0,        1'b0, 32'h000001FF, 4'd6},  // R6
        '{1'b0, 16'h2088, 32'd0,        1'b1, 32'd0,        4'd6},  // R6
        '{1'b1, 16'h4000, 32'd3,        1'b0, 32'd0,        4'd7},  // R7
        '{1'b0, 16'h4000, 32'd0,        1'b0, 32'd3,        4'd7},  // R7
        '{1'b0, 16'h4008, 32'd0,        1'b1, 32'd0,        4'd7},  // R7
        '{1'b1, 16'h1000, 32'hFFFF,     1'b0, 32'd0,        4'd5},  // R5
        '{1'b0, 16'h1000, 32'd0,        1'b0, 32'd0,        4'd5},  // R5
        '{1'b0, 16'h1008, 32'd0,        1'b1, 32'd0,        4'd5},  // R5
        '{1'b0, 16'h3000, 32'd0,        1'b1, 32'd0,        4'd8},  // R8
        '{1'b0, 16'h6000, 32'd0,        1'b1, 32'd0,        4'd8},  // R8
        '{1'b0, 16'h2000, 32'd0,        1'b0, 32'd0,        4'd6}   // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [15:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic e);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        rd = rdata;
        e  = err;
        check("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        logic [31:0] rd;
        logic e;
        acc(1'b1, a, d, rd, e);
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] rd;
        logic e;
        acc(1'b0, a, 32'd0, rd, e);
        check(tag, rd, exp);
        check(tag, 32'(e), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 err", 32'(err), 32'd0);
        check("R1 irq_o", 32'(irq_o), 32'd0);
        rd_chk("R1 prio", 16'h0000, 32'd0);
        rd_chk("R1 thr", 16'h5000, 32'd0);
        rd_chk("R1 enable", 16'h2084, 32'd0);
        rd_chk("R1 pending", 16'h1000, 32'd0);

        for (int i = 0; i < NV; i++) begin
            acc(VECS[i].w, VECS[i].a, VECS[i].d, rd, e);
            check($sformatf("R%0d vec %0d rdata", VECS[i].tag, i), rd, VECS[i].r);
            check($sformatf("R%0d vec %0d err", VECS[i].tag, i), 32'(e), 32'(VECS[i].e));
        end

        // clean up table state
        wr(16'h2080, 32'd0);
        wr(16'h2084, 32'd0);
        wr(16'h4000, 32'd0);

        // priorities: src3=2, src5=6, src7=6, src40=4
        wr(16'h0008, 32'd2);
        wr(16'h0010, 32'd6);
        wr(16'h0018, 32'd6);
        wr(16'h009C, 32'd4);
        wr(16'h2000, 32'h000000A8);
        wr(16'h2004, 32'h00000100);
        wr(16'h2080, 32'h00000008);
        wr(16'h5000, 32'd2);
        check("R11 idle irq", 32'(irq_o), 32'd0);

        // R12 level capture
        src_in[2] = 1'b1; src_in[4] = 1'b1; src_in[6] = 1'b1; src_in[39] = 1'b1;
        rd_chk("R12 pend word0", 16'h1000, 32'h000000A8);
        rd_chk("R5 pend word1", 16'h1004, 32'h00000100);
        check("R11 irq ctx0 only", 32'(irq_o), 32'd1);

        // R9 ordering: priority, then lowest ID
        rd_chk("R9 claim tie", 16'h4004, 32'd5);
        rd_chk("R10 pend after claim", 16'h1000, 32'h00000088);
        rd_chk("R9 claim second", 16'h4004, 32'd7);
        rd_chk("R9 claim word1", 16'h4004, 32'd40);
        rd_chk("R9 claim low", 16'h4004, 32'd3);
        rd_chk("R9 claim none", 16'h4004, 32'd0);
        check("R11 irq cleared", 32'(irq_o), 32'd0);
        rd_chk("R10 held word0", 16'h1000, 32'd0);

        // R10 completion re-pends
        wr(16'h4004, 32'd5);
        rd_chk("R10 re-pend", 16'h1000, 32'h00000020);
        check("R11 irq after complete", 32'(irq_o), 32'd1);

        // context 1: source 3 held by ctx0 claim
        wr(16'h5000, 32'd1);
        check("R11 ctx1 held", 32'(irq_o[1]), 32'd0);
        rd_chk("R10 ctx1 claim held", 16'h5004, 32'd0);
        wr(16'h5004, 32'd3);
        rd_chk("R10 cross complete", 16'h1000, 32'h00000028);
        check("R11 ctx1 irq", 32'(irq_o[1]), 32'd1);
        rd_chk("R9 ctx1 claim", 16'h5004, 32'd3);
        check("R11 ctx1 after claim", 32'(irq_o[1]), 32'd0);

        // R9 strictly above threshold
        wr(16'h4000, 32'd6);
        check("R11 thr equal", 32'(irq_o[0]), 32'd0);
        rd_chk("R9 thr equal claim", 16'h4004, 32'd0);
        rd_chk("R9 no side effect", 16'h1000, 32'h00000020);
        wr(16'h4000, 32'd5);
        check("R11 thr below", 32'(irq_o[0]), 32'd1);
        rd_chk("R9 thr below claim", 16'h4004, 32'd5);

        // R9 priority zero never eligible
        wr(16'h4004, 32'd7);
        wr(16'h0018, 32'd0);
        wr(16'h4000, 32'd0);
        rd_chk("R9 prio0 pending", 16'h1000, 32'h00000080);
        check("R9 prio0 irq", 32'(irq_o[0]), 32'd0);
        rd_chk("R9 prio0 claim", 16'h4004, 32'd0);

        // R12 low level does not pend
        src_in = '0;
        wr(16'h4004, 32'd5);
        @(negedge clk);
        rd_chk("R12 low no pend", 16'h1000, 32'h00000080);

        // R2 request during response ignored
        wr(16'h4000, 32'd2);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 16'h4000; wdata = 32'd4;
        @(negedge clk);
        check("R2 first rsp", 32'(rsp_valid), 32'd1);
        wdata = 32'd6;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check("R2 no second rsp", 32'(rsp_valid), 32'd0);
        rd_chk("R2 ignored write", 16'h4000, 32'd4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule